// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block is the host-side controller for an asynchronous EDO DRAM with a 4-bit data bus and an 11-bit multiplexed address. A client issues one read or write at a time over a valid/ready port. The request carries a 22-bit word address, whose upper half is the row and whose lower half is the column. The block turns each request into row and column strobes, the write enable, the output enable and the address mux. Every analog timing is turned into a whole number of cycles of the system clock.

After an access the row stays open. A later request to the same row then costs only a column cycle. A request to another row, a refresh request or the end of the page-open budget closes the row. Closing means raising RAS and waiting the precharge time. Read data is sampled on the clock edge that ends the CAS-low window, and OE stays low up to that edge. The EDO output hold lets CAS rise right after the sample. An external scheduler asks for refresh. The block then closes the row and runs a CAS-before-RAS cycle, and it acknowledges with a one-cycle grant once precharge is complete.

Top module: `edo_page_seq`

## Requirements
- R1: After reset, dram_ras_n, dram_cas_n, dram_we_n and dram_oe_n are high, dram_dq_oe is low, rsp_valid and ref_gnt are low, and req_ready is high.
- R2: Only one request is outstanding. In the cycle after a request is accepted, req_ready is low. It stays low until the column cycle and any precharge are finished.
- R3: The row is req_addr[21:11] and the column is req_addr[10:0]. The row is on dram_addr when dram_ras_n falls, and the column is on dram_addr when dram_cas_n falls.
- R4: A read that starts with the row closed raises rsp_valid on edge 1 + N_RCD + 1 + N_CAS after the accepting edge. With the defaults this is edge 13.
- R5: A request to the open row causes no new fall of dram_ras_n. A read of this kind raises rsp_valid on edge 1 + N_CAS after acceptance, which is edge 4 with the defaults.
- R6: A request to a different row closes the row first. A read of this kind raises rsp_valid on edge N_RP + 1 + N_RCD + 1 + N_CAS, which is edge 19 with the defaults, and it causes one new fall of dram_ras_n.
- R7: A write is an early write. At the fall of dram_cas_n, dram_we_n is low, dram_oe_n is high, dram_dq_oe is high and dram_dq_out carries the write data.
- R8: dram_oe_n is low while the read CAS window lasts. rsp_rdata is the value on dram_dq_in at the last edge before dram_cas_n rises. rsp_valid is a one-cycle pulse and appears only for reads.
- R9: dram_ras_n never stays low for N_PAGE consecutive cycles, where N_PAGE is the page-open limit in cycles. An idle open row is closed before that limit.
- R10: Before each fall of dram_ras_n, dram_ras_n has been high for at least N_RP cycles.
- R11: While ref_req is high, req_ready is low. The block closes any open row and drops dram_cas_n before dram_ras_n. After precharge it pulses ref_gnt for one cycle, with both strobes high.
- R12: Each timing count is the time in ns divided by CLK_PERIOD_NS and rounded up. With a 5 ns clock this gives N_RCD = 8 (37 ns), N_CAS = 3 (13 ns) and N_RP = 6 (30 ns).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address, row in the upper 11 bits |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 4 | Read data |
| ref_req | input | 1 | Refresh wanted |
| ref_gnt | output | 1 | Refresh done pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
The bench counts the edges from the accepting edge until rsp_valid appears. It expects edge 13 for a read to a closed row, edge 4 for a read to the open row and edge 19 for a read to a different row. It derives these numbers from the nanosecond figures on its own. It reads rsp_valid at the falling clock edge after the edge that produces it, and checks one falling edge later that the pulse is gone. A memory model in the bench latches the row and column on the strobe edges and records WE, OE and the data at each fall of CAS. It also watches the length of each RAS-high run, so every address, early-write and precharge check is made against what the memory saw. For the page limit, the bench leaves a row idle longer than its budget and then checks that RAS has risen. For refresh, the bench waits up to 200 cycles for ref_gnt.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ROW, S_RCD, S_COL, S_CAS, S_CP, S_OPEN,
    S_PRE, S_RCSR, S_RRAS, S_RPRE
  } seq_state_e;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int ns2cyc(int ns, int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int at_least_one(int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/edo_cyc_timer.sv
module edo_cyc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = val_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R12: a loaded count always runs down by one per cycle
  a_r12_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q != $past(cnt_q)));
endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int RW       = 11,
  parameter int OPEN_MAX = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [RW-1:0] row_i,
  input  logic          active_i,
  input  logic [RW-1:0] cmp_row_i,
  output logic          hit_o,
  output logic          limit_o
);
  localparam int CW = $clog2(OPEN_MAX + 2);

  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] age_q, age_d;

  always_comb begin
    row_d = row_q;
    age_d = age_q;
    if (start_i) begin
      row_d = row_i;
      age_d = '0;
    end else if (active_i && !limit_o) begin
      age_d = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      age_q <= '0;
    end else begin
      row_q <= row_d;
      age_q <= age_d;
    end
  end

  assign hit_o   = (cmp_row_i == row_q);
  assign limit_o = (age_q >= CW'(OPEN_MAX));

  // R9: the page age saturates at its limit
  a_r9_age_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_o && !start_i) |=> limit_o);
endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq
  import edo_seq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_RCD_NS      = 37,
  parameter int T_CAS_NS      = 13,
  parameter int T_PC_NS       = 20,
  parameter int T_RP_NS       = 30,
  parameter int T_CSR_NS      = 5,
  parameter int T_RAS_NS      = 50,
  parameter int T_PAGE_NS     = 10000,
  parameter int RW            = 11,
  parameter int DW            = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [2*RW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          ref_req,
  output logic          ref_gnt,
  output logic          dram_ras_n,
  output logic          dram_cas_n,
  output logic          dram_we_n,
  output logic          dram_oe_n,
  output logic [RW-1:0] dram_addr,
  output logic [DW-1:0] dram_dq_out,
  output logic          dram_dq_oe,
  input  logic [DW-1:0] dram_dq_in
);
  localparam int N_RCD    = ns2cyc(T_RCD_NS, CLK_PERIOD_NS);
  localparam int N_CAS    = ns2cyc(T_CAS_NS, CLK_PERIOD_NS);
  localparam int N_RP     = ns2cyc(T_RP_NS, CLK_PERIOD_NS);
  localparam int N_CSR    = ns2cyc(T_CSR_NS, CLK_PERIOD_NS);
  localparam int N_RAS    = ns2cyc(T_RAS_NS, CLK_PERIOD_NS);
  localparam int N_PAGE   = ns2cyc(T_PAGE_NS, CLK_PERIOD_NS);
  localparam int N_CP     = at_least_one(ns2cyc(T_PC_NS, CLK_PERIOD_NS) - N_CAS - 1);
  localparam int OPEN_MAX = N_PAGE - (N_CAS + N_CP + 3);
  localparam int TW       = $clog2(N_RCD + N_CAS + N_RP + N_CSR + N_RAS + N_CP + 1);
  localparam int PW       = $clog2(N_PAGE + 2) + 1;

  seq_state_e    state_q, state_d;
  logic          tmr_ld, tmr_done;
  logic [TW-1:0] tmr_val;
  logic [RW-1:0] rq_row_q, rq_col_q;
  logic          rq_we_q, pend_q, pend_d;
  logic [DW-1:0] rq_wd_q;
  logic          rsp_valid_q, ref_gnt_q;
  logic [DW-1:0] rsp_data_q;
  logic          accept, row_hit, page_limit, in_col, row_low;

  edo_cyc_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_ld), .val_i(tmr_val), .done_o(tmr_done)
  );

  edo_row_tracker #(.RW(RW), .OPEN_MAX(OPEN_MAX)) u_row (
    .clk(clk), .rst_n(rst_n), .start_i(state_q == S_ROW), .row_i(rq_row_q),
    .active_i(row_low), .cmp_row_i(req_addr[2*RW-1:RW]),
    .hit_o(row_hit), .limit_o(page_limit)
  );

  assign req_ready = !ref_req &&
                     ((state_q == S_IDLE) || (state_q == S_OPEN && !page_limit));
  assign accept    = req_valid && req_ready;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_req && !ref_gnt_q) begin
          state_d = S_RCSR; tmr_ld = 1'b1; tmr_val = TW'(N_CSR - 1);
        end else if (accept) begin
          state_d = S_ROW;
        end
      end
      S_ROW: begin
        state_d = S_RCD; pend_d = 1'b0; tmr_ld = 1'b1; tmr_val = TW'(N_RCD - 1);
      end
      S_RCD:  if (tmr_done) state_d = S_COL;
      S_COL:  begin state_d = S_CAS; tmr_ld = 1'b1; tmr_val = TW'(N_CAS - 1); end
      S_CAS:  if (tmr_done) begin
                state_d = S_CP; tmr_ld = 1'b1; tmr_val = TW'(N_CP - 1);
              end
      S_CP:   if (tmr_done) state_d = S_OPEN;
      S_OPEN: begin
        if (ref_req || page_limit) begin
          state_d = S_PRE; tmr_ld = 1'b1; tmr_val = TW'(N_RP - 1);
        end else if (accept && row_hit) begin
          state_d = S_COL;
        end else if (accept) begin
          state_d = S_PRE; pend_d = 1'b1; tmr_ld = 1'b1; tmr_val = TW'(N_RP - 1);
        end
      end
      S_PRE:  if (tmr_done) state_d = pend_q ? S_ROW : S_IDLE;
      S_RCSR: if (tmr_done) begin
                state_d = S_RRAS; tmr_ld = 1'b1; tmr_val = TW'(N_RAS - 1);
              end
      S_RRAS: if (tmr_done) begin
                state_d = S_RPRE; tmr_ld = 1'b1; tmr_val = TW'(N_RP - 1);
              end
      S_RPRE: if (tmr_done) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      pend_q      <= 1'b0;
      rq_row_q    <= '0;
      rq_col_q    <= '0;
      rq_we_q     <= 1'b0;
      rq_wd_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      ref_gnt_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      pend_q      <= pend_d;
      rsp_valid_q <= (state_q == S_CAS) && tmr_done && !rq_we_q;
      ref_gnt_q   <= (state_q == S_RPRE) && tmr_done;
      if (accept) begin
        rq_row_q <= req_addr[2*RW-1:RW];
        rq_col_q <= req_addr[RW-1:0];
        rq_we_q  <= req_write;
        rq_wd_q  <= req_wdata;
      end
      if ((state_q == S_CAS) && tmr_done && !rq_we_q) rsp_data_q <= dram_dq_in;
    end
  end

  // Strobe and address decode from the state register
  assign in_col      = (state_q == S_COL) || (state_q == S_CAS);
  assign row_low     = (state_q inside {S_RCD, S_COL, S_CAS, S_CP, S_OPEN});
  assign dram_ras_n  = !(row_low || state_q == S_RRAS);
  assign dram_cas_n  = !(state_q inside {S_CAS, S_RCSR, S_RRAS});
  assign dram_we_n   = !(in_col && rq_we_q);
  assign dram_oe_n   = !(in_col && !rq_we_q);
  assign dram_dq_oe  = in_col && rq_we_q;
  assign dram_dq_out = rq_wd_q;
  assign dram_addr   = in_col ? rq_col_q : rq_row_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_data_q;
  assign ref_gnt     = ref_gnt_q;

  // Run-length counters for the strobe-timing checks
  logic [PW-1:0] lo_run_q, hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run_q <= '0;
      hi_run_q <= PW'(N_RP);
    end else begin
      lo_run_q <= dram_ras_n ? '0 : ((lo_run_q == '1) ? lo_run_q : lo_run_q + 1'b1);
      hi_run_q <= !dram_ras_n ? '0 :
                  ((hi_run_q >= PW'(N_RP)) ? hi_run_q : hi_run_q + 1'b1);
    end
  end

  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  a_r7_write_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n);
  a_r8_rsp_at_cas_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(dram_cas_n));
  a_r9_page_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run_q < PW'(N_PAGE));
  a_r10_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras_n && hi_run_q != '0) |-> (hi_run_q >= PW'(N_RP)));
  a_r11_gnt_closed: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n));
endmodule

// File: tb/edo_page_seq_tb.sv
module edo_page_seq_tb;
  localparam int PER = 5;
  localparam int N_RCD = (37 + PER - 1) / PER;
  localparam int N_CAS = (13 + PER - 1) / PER;
  localparam int N_RP  = (30 + PER - 1) / PER;
  localparam int LAT_CLOSED = 1 + N_RCD + 1 + N_CAS;
  localparam int LAT_HIT    = 1 + N_CAS;
  localparam int LAT_MISS   = N_RP + LAT_CLOSED;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [21:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ref_gnt;
  logic [3:0] rsp_rdata, dram_dq_out, dram_dq_in;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [10:0] dram_addr;

  always #(PER * 500ps) clk = ~clk;

  edo_page_seq #(.T_PAGE_NS(400)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  // Memory model: 64 cells picked by low row and column bits
  logic [3:0]  mem [64];
  logic [3:0]  shadow [64];
  logic [10:0] row_l, col_l;
  logic [3:0]  dout;
  logic cas_we, cas_oe, cas_dqoe, cbr_seen;
  logic [3:0] cas_dq;
  int ras_falls = 0, hi_cnt = 1000, min_hi = 1000;

  initial for (int i = 0; i < 64; i++) begin
    mem[i] = 4'((i * 5 + 1) % 16);
    shadow[i] = 4'((i * 5 + 1) % 16);
  end

  always @(negedge dram_ras_n) begin
    row_l = dram_addr;
    ras_falls++;
    if (!dram_cas_n) cbr_seen = 1'b1;
  end
  always @(negedge dram_cas_n) if (!dram_ras_n) begin
    col_l = dram_addr;
    cas_we = dram_we_n; cas_oe = dram_oe_n; cas_dqoe = dram_dq_oe; cas_dq = dram_dq_out;
    if (!dram_we_n) mem[{row_l[2:0], dram_addr[2:0]}] = dram_dq_out;
    else dout = mem[{row_l[2:0], dram_addr[2:0]}];
  end
  assign dram_dq_in = dram_oe_n ? 4'h0 : dout;

  always @(posedge clk) begin
    if (dram_ras_n) hi_cnt++;
    else begin
      if (hi_cnt > 0 && hi_cnt < min_hi) min_hi = hi_cnt;
      hi_cnt = 0;
    end
  end

  int errs = 0, nchk = 0, cyc = 0;
  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [10:0] row;
    logic [10:0] col;
    logic [3:0]  wd;
    logic [1:0]  kind;   // 0 closed, 1 hit, 2 miss
    logic [1:0]  rasd;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 11'd5,    11'd3,    4'hA, 2'd0, 2'd1},
    '{1'b0, 11'd5,    11'd3,    4'h0, 2'd1, 2'd0},
    '{1'b1, 11'd5,    11'd7,    4'h3, 2'd1, 2'd0},
    '{1'b0, 11'd5,    11'd7,    4'h0, 2'd1, 2'd0},
    '{1'b0, 11'd9,    11'd3,    4'h0, 2'd2, 2'd1},
    '{1'b1, 11'd9,    11'd0,    4'hC, 2'd1, 2'd0},
    '{1'b0, 11'd9,    11'd0,    4'h0, 2'd1, 2'd0},
    '{1'b0, 11'd2047, 11'd2047, 4'h0, 2'd2, 2'd1},
    '{1'b0, 11'd0,    11'd0,    4'h0, 2'd2, 2'd1}
  };

  task automatic do_op(input vec_t v);
    int f0, lat, exp_lat;
    logic [5:0] idx;
    idx = {v.row[2:0], v.col[2:0]};
    exp_lat = (v.kind == 2'd0) ? LAT_CLOSED : (v.kind == 2'd1) ? LAT_HIT : LAT_MISS;
    while (!req_ready) @(negedge clk);
    f0 = ras_falls;
    req_valid = 1'b1; req_write = v.we; req_addr = {v.row, v.col}; req_wdata = v.wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready after accept", int'(req_ready), 0);
    if (!v.we) begin
      lat = 0;
      while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
      chk(lat == exp_lat, "R4/R5/R6/R12 read latency", lat, exp_lat);
      chk(rsp_rdata == shadow[idx], "R8 read data", int'(rsp_rdata), int'(shadow[idx]));
      chk(cas_we == 1'b1, "R8 WE high on read", int'(cas_we), 1);
      @(negedge clk);
      chk(!rsp_valid, "R8 single pulse", int'(rsp_valid), 0);
    end else begin
      while (!req_ready) @(negedge clk);
      chk(!cas_we && cas_oe && cas_dqoe, "R7 early write strobes",
          int'({cas_we, cas_oe, cas_dqoe}), 3'b011);
      chk(cas_dq == v.wd, "R7 write data", int'(cas_dq), int'(v.wd));
      chk(!rsp_valid, "R8 no response on write", int'(rsp_valid), 0);
      shadow[idx] = v.wd;
    end
    chk(row_l == v.row, "R3 row latched", int'(row_l), int'(v.row));
    chk(col_l == v.col, "R3 column latched", int'(col_l), int'(v.col));
    chk(ras_falls - f0 == int'(v.rasd), "R5/R6 RAS falls", ras_falls - f0, int'(v.rasd));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errs++; nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
      end
    end
  end

  initial begin
    int w;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle",
        int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 4'hF);
    chk(!dram_dq_oe && !rsp_valid && !ref_gnt, "R1 outputs low",
        int'({dram_dq_oe, rsp_valid, ref_gnt}), 0);
    chk(req_ready, "R1 ready", int'(req_ready), 1);

    foreach (VEC[i]) do_op(VEC[i]);

    // R9: an idle open row is closed inside its budget
    repeat (100) @(negedge clk);
    chk(dram_ras_n, "R9 idle row closed", int'(dram_ras_n), 1);
    v = '{1'b0, 11'd0, 11'd0, 4'h0, 2'd0, 2'd1};
    do_op(v);

    // R11: refresh from an open row
    cbr_seen = 1'b0;
    ref_req = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R11 ready held low", int'(req_ready), 0);
    w = 0;
    while (!ref_gnt && w < 200) begin @(negedge clk); w++; end
    chk(ref_gnt, "R11 grant seen", int'(ref_gnt), 1);
    chk(cbr_seen, "R11 CAS before RAS", int'(cbr_seen), 1);
    chk(dram_ras_n && dram_cas_n, "R11 strobes high at grant",
        int'({dram_ras_n, dram_cas_n}), 3);
    ref_req = 1'b0;
    @(negedge clk);
    chk(!ref_gnt, "R11 grant one cycle", int'(ref_gnt), 0);
    do_op(v);

    chk(min_hi >= N_RP, "R10 precharge length", min_hi, N_RP);
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule